// File: doc/BRIEF.md
# Prefetch Issue Buffer

This block holds the prefetch requests that missed in the primary cache until their lines come back. Each prefetch arrives with its line address and the primary-tag lookup result from the same cycle. A hit is thrown away. A miss takes a free slot, unless the line is already held, in which case it merges with the existing slot. Slots that have not yet been issued go to the secondary-cache/memory request port over a valid/ready handshake, oldest first. A slot is released when the fill-return acknowledge for its line arrives.

When all slots are occupied, a new missing prefetch is handled according to a policy input. In one setting the block holds the processor stall asserted until a slot frees. In the other setting the prefetch is dropped. The block also receives the single demand miss that may be outstanding. A demand miss that matches a waiting prefetch removes that prefetch, so the miss goes out instead. A demand miss that matches a prefetch already in flight leaves the slot alone and raises a flag, so the demand can wait on that fill.

Top module: `prefetch_issue_buffer`

## Requirements
- R1: After reset the buffer is empty: `req_valid_o`, `stall_o` and `dm_inflight_o` are 0.
- R2: A prefetch presented with `pf_l1_hit_i`=1 allocates nothing and is never sent on the request port.
- R3: A missing prefetch takes a slot and is offered on `req_valid_o`/`req_addr_o`. It is marked issued in the cycle where `req_valid_o` and `req_ready_i` are both 1, and it is never offered again.
- R4: Unissued slots are offered in the order they were allocated, oldest first.
- R5: A missing prefetch whose line is already held merges with that slot. It allocates nothing and never raises the stall, even when the buffer is full.
- R6: The buffer has 16 slots. With `drop_mode_i`=0 and all 16 slots occupied, a missing, non-merging prefetch raises `stall_o` combinationally in the same cycle. The stall stays up until a slot frees, and the prefetch is allocated on the first clock edge after that.
- R7: With `drop_mode_i`=1 and the buffer full, a missing prefetch is discarded and `stall_o` stays 0.
- R8: A demand miss (`dm_valid_i`) to a held, unissued line removes that slot in the same clock edge, so the line is never offered. `dm_inflight_o` stays 0.
- R9: A demand miss to a held, issued line drives `dm_inflight_o`=1 in the same cycle and keeps the slot, so a later prefetch to that line still merges.
- R10: `fill_valid_i` with the address of an issued slot frees that slot at the clock edge, and the line can then be allocated again.
- R11: A missing prefetch and a demand miss to the same line in the same cycle leave nothing allocated for that line. The demand takes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drop_mode_i | input | 1 | Full policy: 0 = stall, 1 = drop |
| pf_valid_i | input | 1 | Prefetch presented this cycle |
| pf_addr_i | input | ADDR_W | Prefetch line address |
| pf_l1_hit_i | input | 1 | Primary tag lookup hit for the prefetch |
| stall_o | output | 1 | Processor stall, prefetch cannot be accepted |
| dm_valid_i | input | 1 | Demand miss presented |
| dm_addr_i | input | ADDR_W | Demand miss line address |
| dm_inflight_o | output | 1 | Demand miss matches an issued prefetch |
| req_valid_o | output | 1 | Request offered downstream |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | ADDR_W | Requested line address |
| fill_valid_i | input | 1 | Fill return acknowledge |
| fill_addr_i | input | ADDR_W | Line address of the returned fill |

## Verification
`stall_o`, `dm_inflight_o` and `req_valid_o`/`req_addr_o` are combinational views of the inputs and the registered slots. The bench therefore drives each input at the falling edge and reads these outputs 1 time unit later in the same half cycle. Allocation, cancellation, issue and release take effect at the next rising edge. Their results are checked from the following falling edge onward: through the offered request, through the log of accepted handshakes, or through the stall that a refill of all 16 slots produces. Order and merge/cancel effects are verified by comparing the complete handshake log with address sequences computed in the bench.

// File: rtl/pib_pkg.sv
package pib_pkg;
  typedef enum logic {
    FULL_STALL = 1'b0,
    FULL_DROP  = 1'b1
  } full_policy_e;
endpackage

// File: rtl/pib_addr_cam.sv
module pib_addr_cam #(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 26
) (
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] entry_addr_i,
  input  logic [N_ENTRIES-1:0]             entry_valid_i,
  input  logic                             key_valid_i,
  input  logic [ADDR_W-1:0]                key_i,
  output logic [N_ENTRIES-1:0]             match_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = key_valid_i & entry_valid_i[g] & (entry_addr_i[g] == key_i);
  end
endmodule

// File: rtl/pib_age_matrix.sv
module pib_age_matrix #(
  parameter int N_ENTRIES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] alloc_i,
  input  logic [N_ENTRIES-1:0] req_i,
  output logic [N_ENTRIES-1:0] gnt_o
);
  // older_q[i][j]: slot i was allocated before slot j
  logic [N_ENTRIES-1:0][N_ENTRIES-1:0] older_q;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_row
    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_q[i][j] = 1'b0;
      end else begin : g_cell
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)         older_q[i][j] <= 1'b0;
          else if (alloc_i[j]) older_q[i][j] <= 1'b1;
          else if (alloc_i[i]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_gnt
    logic [N_ENTRIES-1:0] beaten;
    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_b
      assign beaten[j] = req_i[j] & older_q[j][i];
    end
    assign gnt_o[i] = req_i[i] & ~(|beaten);
  end
endmodule

// File: rtl/pib_free_pick.sv
module pib_free_pick #(
  parameter int N_ENTRIES = 16
) (
  input  logic [N_ENTRIES-1:0] free_i,
  output logic [N_ENTRIES-1:0] pick_o,
  output logic                 any_o
);
  assign pick_o = free_i & (~free_i + N_ENTRIES'(1));
  assign any_o  = |free_i;
endmodule

// File: rtl/prefetch_issue_buffer.sv
module prefetch_issue_buffer
  import pib_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drop_mode_i,
  input  logic              pf_valid_i,
  input  logic [ADDR_W-1:0] pf_addr_i,
  input  logic              pf_l1_hit_i,
  output logic              stall_o,
  input  logic              dm_valid_i,
  input  logic [ADDR_W-1:0] dm_addr_i,
  output logic              dm_inflight_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i
);
  logic [N_ENTRIES-1:0]             valid_q, issued_q;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q;

  logic [N_ENTRIES-1:0] pf_match, dm_match, fill_match;
  logic [N_ENTRIES-1:0] cancel_vec, free_vec, issue_vec, alloc_vec, cand_vec, gnt_vec, pick_vec;
  logic                 pf_miss, pf_merge, pf_same_dm, pf_need, full, any_free, alloc_en;
  full_policy_e         policy;

  assign policy = full_policy_e'(drop_mode_i);

  pib_addr_cam #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cam_pf (
    .entry_addr_i (addr_q), .entry_valid_i (valid_q),
    .key_valid_i  (pf_valid_i), .key_i (pf_addr_i), .match_o (pf_match));

  pib_addr_cam #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cam_dm (
    .entry_addr_i (addr_q), .entry_valid_i (valid_q),
    .key_valid_i  (dm_valid_i), .key_i (dm_addr_i), .match_o (dm_match));

  pib_addr_cam #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cam_fill (
    .entry_addr_i (addr_q), .entry_valid_i (valid_q & issued_q),
    .key_valid_i  (fill_valid_i), .key_i (fill_addr_i), .match_o (fill_match));

  assign pf_miss    = pf_valid_i & ~pf_l1_hit_i;
  assign pf_merge   = |pf_match;
  assign pf_same_dm = dm_valid_i & (dm_addr_i == pf_addr_i);
  assign pf_need    = pf_miss & ~pf_merge & ~pf_same_dm;

  pib_free_pick #(.N_ENTRIES(N_ENTRIES)) u_free (
    .free_i (~valid_q), .pick_o (pick_vec), .any_o (any_free));

  assign full      = ~any_free;
  assign alloc_en  = pf_need & any_free;
  assign alloc_vec = pick_vec & {N_ENTRIES{alloc_en}};
  assign stall_o   = pf_need & full & (policy == FULL_STALL);

  // demand miss: unissued match is cancelled, issued match is reported
  assign cancel_vec    = dm_match & ~issued_q;
  assign dm_inflight_o = |(dm_match & issued_q);

  assign cand_vec = valid_q & ~issued_q & ~cancel_vec;

  pib_age_matrix #(.N_ENTRIES(N_ENTRIES)) u_age (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .alloc_i (alloc_vec), .req_i (cand_vec), .gnt_o (gnt_vec));

  assign req_valid_o = |gnt_vec;
  assign issue_vec   = gnt_vec & {N_ENTRIES{req_ready_i}};

  always_comb begin
    req_addr_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (gnt_vec[i]) req_addr_o = req_addr_o | addr_q[i];
    end
  end

  assign free_vec = cancel_vec | fill_match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]  <= 1'b0;
        issued_q[g] <= 1'b0;
        addr_q[g]   <= '0;
      end else if (alloc_vec[g]) begin
        valid_q[g]  <= 1'b1;
        issued_q[g] <= 1'b0;
        addr_q[g]   <= pf_addr_i;
      end else if (free_vec[g]) begin
        valid_q[g]  <= 1'b0;
        issued_q[g] <= 1'b0;
      end else if (issue_vec[g]) begin
        issued_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pib_checker.sv
module pib_checker #(
  parameter int N_ENTRIES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 drop_mode_i,
  input logic                 pf_valid_i,
  input logic                 pf_l1_hit_i,
  input logic                 dm_valid_i,
  input logic                 stall_o,
  input logic                 dm_inflight_o,
  input logic                 req_valid_o,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] issued_q
);
  assert_hit_no_alloc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_i && pf_l1_hit_i) |=> ($countones(valid_q) <= $past($countones(valid_q))));

  assert_issued_is_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q & ~valid_q) == '0);

  assert_req_has_waiting_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (|(valid_q & ~issued_q)));

  assert_stall_when_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (&valid_q));

  assert_no_stall_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !drop_mode_i);

  assert_inflight_needs_dm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_inflight_o |-> (dm_valid_i && (|issued_q)));
endmodule

bind prefetch_issue_buffer pib_checker #(.N_ENTRIES(N_ENTRIES)) u_pib_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .drop_mode_i   (drop_mode_i),
  .pf_valid_i    (pf_valid_i),
  .pf_l1_hit_i   (pf_l1_hit_i),
  .dm_valid_i    (dm_valid_i),
  .stall_o       (stall_o),
  .dm_inflight_o (dm_inflight_o),
  .req_valid_o   (req_valid_o),
  .valid_q       (valid_q),
  .issued_q      (issued_q)
);

// File: tb/prefetch_issue_buffer_tb.sv
module prefetch_issue_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int AW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic drop_mode_i = 1'b0;
  logic pf_valid_i = 1'b0, pf_l1_hit_i = 1'b0;
  logic [AW-1:0] pf_addr_i = '0;
  logic dm_valid_i = 1'b0;
  logic [AW-1:0] dm_addr_i = '0;
  logic req_ready_i = 1'b0;
  logic fill_valid_i = 1'b0;
  logic [AW-1:0] fill_addr_i = '0;
  logic stall_o, dm_inflight_o, req_valid_o;
  logic [AW-1:0] req_addr_o;

  int n_cmp = 0, n_bad = 0;
  int log_n = 0;
  logic [AW-1:0] log_q [0:255];
  logic last_inflight;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prefetch_issue_buffer #(.N_ENTRIES(N), .ADDR_W(AW)) dut_i (.*);

  always @(posedge clk_i) begin
    if (rst_ni && req_valid_o && req_ready_i && log_n < 256) begin
      log_q[log_n] = req_addr_o;
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pf(input int a, input bit hit);
    pf_valid_i = 1'b1; pf_addr_i = AW'(a); pf_l1_hit_i = hit;
    tick();
    pf_valid_i = 1'b0; pf_l1_hit_i = 1'b0;
  endtask

  task automatic dm(input int a);
    dm_valid_i = 1'b1; dm_addr_i = AW'(a);
    #1 last_inflight = dm_inflight_o;
    tick();
    dm_valid_i = 1'b0;
  endtask

  task automatic fill(input int a);
    fill_valid_i = 1'b1; fill_addr_i = AW'(a);
    tick();
    fill_valid_i = 1'b0;
  endtask

  task automatic drain(input int n);
    req_ready_i = 1'b1;
    repeat (n) tick();
    req_ready_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    // R1 reset state
    check("R1 req_valid", req_valid_o, 0);
    check("R1 stall", stall_o, 0);
    check("R1 inflight", dm_inflight_o, 0);

    // R2 primary hit discarded
    pf('h10, 1'b1);
    #1 check("R2 req_valid", req_valid_o, 0);
    base = log_n;
    drain(3);
    check("R2 log", log_n - base, 0);

    // R3/R4 in-order issue
    for (int i = 0; i < 5; i++) pf('h100 + i * 7, 1'b0);
    #1 check("R3 req_valid", req_valid_o, 1);
    check("R4 head", req_addr_o, 'h100);
    base = log_n;
    drain(5);
    check("R3 issued count", log_n - base, 5);
    for (int i = 0; i < 5; i++) check("R4 order", log_q[base + i], 'h100 + i * 7);
    #1 check("R3 not reoffered", req_valid_o, 0);
    for (int i = 0; i < 5; i++) fill('h100 + i * 7);

    // R5 merge
    pf('h150, 1'b0); pf('h150, 1'b0); pf('h151, 1'b0);
    base = log_n;
    drain(4);
    check("R5 count", log_n - base, 2);
    check("R5 first", log_q[base], 'h150);
    check("R5 second", log_q[base + 1], 'h151);
    fill('h150); fill('h151);

    // R6 full with stall policy
    for (int i = 0; i < N; i++) pf('h200 + i, 1'b0);
    pf_valid_i = 1'b1; pf_addr_i = AW'('h205);
    #1 check("R5 merge when full", stall_o, 0);
    pf_addr_i = AW'('h300);
    #1 check("R6 stall full", stall_o, 1);
    tick();
    #1 check("R6 stall held", stall_o, 1);
    base = log_n;
    drain(1);
    check("R3 single issue", log_n - base, 1);
    #1 check("R6 stall after issue", stall_o, 1);
    fill_valid_i = 1'b1; fill_addr_i = AW'('h200);
    #1 check("R6 stall in fill cycle", stall_o, 1);
    tick();
    fill_valid_i = 1'b0;
    #1 check("R10 slot freed stall off", stall_o, 0);
    tick();
    pf_valid_i = 1'b0;
    base = log_n;
    drain(20);
    check("R6 count", log_n - base, 16);
    for (int i = 0; i < 15; i++) check("R4 order full", log_q[base + i], 'h201 + i);
    check("R6 stalled pf allocated", log_q[base + 15], 'h300);
    for (int i = 1; i < N; i++) fill('h200 + i);
    fill('h300);

    // R7 drop policy
    drop_mode_i = 1'b1;
    for (int i = 0; i < N; i++) pf('h400 + i, 1'b0);
    pf_valid_i = 1'b1; pf_addr_i = AW'('h4ff);
    #1 check("R7 no stall", stall_o, 0);
    tick();
    pf_valid_i = 1'b0;
    base = log_n;
    drain(20);
    check("R7 count", log_n - base, 16);
    for (int i = 0; i < N; i++) check("R7 no dropped line", log_q[base + i], 'h400 + i);
    for (int i = 0; i < N; i++) fill('h400 + i);
    drop_mode_i = 1'b0;

    // R8 cancel unissued
    pf('h500, 1'b0); pf('h501, 1'b0); pf('h502, 1'b0);
    dm('h500);
    check("R8 inflight", last_inflight, 0);
    base = log_n;
    drain(5);
    check("R8 count", log_n - base, 2);
    check("R8 first", log_q[base], 'h501);
    check("R8 second", log_q[base + 1], 'h502);
    fill('h501); fill('h502);

    // R9 in-flight report, R10 release
    pf('h600, 1'b0);
    drain(1);
    dm('h600);
    check("R9 inflight", last_inflight, 1);
    dm('h777);
    check("R9 no match", last_inflight, 0);
    pf('h600, 1'b0);
    base = log_n;
    drain(3);
    check("R9 entry kept", log_n - base, 0);
    fill('h600);
    pf('h600, 1'b0);
    base = log_n;
    drain(3);
    check("R10 realloc", log_n - base, 1);
    check("R10 addr", log_q[base], 'h600);
    fill('h600);

    // R11 same-cycle prefetch and demand
    pf_valid_i = 1'b1; pf_addr_i = AW'('h700);
    dm_valid_i = 1'b1; dm_addr_i = AW'('h700);
    tick();
    pf_valid_i = 1'b0; dm_valid_i = 1'b0;
    #1 check("R11 nothing offered", req_valid_o, 0);
    base = log_n;
    drain(3);
    check("R11 count", log_n - base, 0);

    #1 check("R1 empty at end", req_valid_o | stall_o, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule